// File: doc/BRIEF.md
# Accumulator Condition Code Generator

This block produces and holds the six condition flags that a fixed-point data ALU reports after each operation on a 56-bit accumulator. The flags are extension (E), unnormalized (U), negative (N), zero (Z), overflow (V) and carry (C). The ALU presents a result, the adder's carry-out and overflow indications, and the current arithmetic modes. On a cycle where the update strobe is high, the block turns these into a 6-bit flag field and registers it.

Two flags depend on a 2-bit scaling mode, which moves the boundary between integer and fraction bits. E reports whether the integer portion carries any significant information. U reports whether the two top bits of the most significant portion are equal. Overflow widens in saturation mode: the result must then also fit in the accumulator without its extension byte, or within 32 bits when 16-bit arithmetic is selected.

A separate write strobe loads all six flags directly from a data word. It wins over an ALU update in the same cycle. When neither strobe is high, the flags hold their value.

Top module: `acc_ccgen`

## Requirements
- R1: The flag field is laid out with C at bit 0, V at bit 1, Z at bit 2, N at bit 3, U at bit 4 and E at bit 5.
- R2: While reset is asserted and after it is released, the flag field reads 6'b100000 (E set, all others clear) until the first load.
- R3: E is loaded clear when the result bits from 55 down to a low bound k are all ones or all zeros, and set otherwise. k is 47 for scale mode 2'b00 (no scaling), 48 for 2'b01 (scale down) and 46 for 2'b10 (scale up).
- R4: U is loaded set when result bits k and k-1 are equal and clear when they differ, with k as in R3 for the same scaling mode.
- R5: N is loaded with result bit 55, and Z is loaded set only when all 56 result bits are zero.
- R6: C is loaded with the adder carry/borrow input.
- R7: With saturation mode off, V is loaded with the adder overflow input.
- R8: With saturation mode on, V is also set when the result is not a 48-bit signed value (bits 55..47 not all equal). With 16-bit arithmetic also on, the test is whether the result is a 32-bit signed value (bits 55..31 not all equal).
- R9: In the reserved scaling mode 2'b11, an update leaves E and U at their previous values while N, Z, V and C load normally.
- R10: On a cycle with neither the update strobe nor the write strobe high, all six flags hold their value.
- R11: The write strobe loads the 6-bit write data into the flag field, taking priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_res | input | 56 | ALU result |
| add_carry | input | 1 | Carry out of (or borrow into) bit 55 |
| add_ovf | input | 1 | Adder overflow of the 56-bit result |
| scale_mode | input | 2 | 00 none, 01 down, 10 up, 11 reserved |
| sat_en | input | 1 | Saturation (limited) arithmetic mode |
| arith16_en | input | 1 | 16-bit arithmetic mode |
| upd | input | 1 | Load flags from the ALU inputs |
| wr_en | input | 1 | Load flags from wr_data |
| wr_data | input | 6 | Direct flag value |
| cc | output | 6 | Registered flag field |

## Verification
The bench sweeps powers of two and their neighbours, both positive and negative, through every scaling mode. It does this for each combination of saturation and 16-bit arithmetic, so the values land exactly on each integer-portion and saturation limit. A design with a bound shifted by one bit would misreport E or U just above or below a power of two. Mixing up the scale-up and scale-down bounds would break only at bits 46 and 48, and an off-by-one window in the 32-bit limit would misreport V at 2^31. The reserved mode is run right after other modes, so a design that reloads E or U from stale logic there is caught. Strobe tests show that a dropped hold or an inverted write/update priority changes the flags seen at the output.

// File: rtl/acc_cc_pkg.sv
package acc_cc_pkg;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_DOWN = 2'b01,
        SC_UP   = 2'b10,
        SC_RSV  = 2'b11
    } scale_e;

    // packed so that bit 5 is E and bit 0 is C
    typedef struct packed {
        logic e;
        logic u;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RST = '{e: 1'b1, default: 1'b0};

endpackage

// File: rtl/acc_cc_window.sv
// E and U for each scaling mode; the integer-portion low bound moves by one
module acc_cc_window #(
    parameter int ACC_W = 56,
    parameter int EXT_W = 8
) (
    input  logic [ACC_W-1:0] res,
    input  logic [1:0]       mode,
    output logic             e_o,
    output logic             u_o,
    output logic             defined_o
);
    import acc_cc_pkg::*;

    localparam int K_NONE = ACC_W - EXT_W - 1;
    localparam int N_MODES = 3;

    function automatic logic top_same(input logic [ACC_W-1:0] v, input int lo);
        logic r;
        r = 1'b1;
        for (int i = 0; i < ACC_W; i++) begin
            if (i >= lo && v[i] != v[ACC_W-1]) r = 1'b0;
        end
        return r;
    endfunction

    logic [N_MODES-1:0] e_m;
    logic [N_MODES-1:0] u_m;

    // index 0: no scaling, 1: scale down (+1), 2: scale up (-1)
    for (genvar g = 0; g < N_MODES; g++) begin : g_mode
        localparam int K = (g == 0) ? K_NONE : (g == 1) ? K_NONE + 1 : K_NONE - 1;
        assign e_m[g] = ~top_same(res, K);
        assign u_m[g] = ~(res[K] ^ res[K-1]);
    end

    always_comb begin
        e_o       = 1'b0;
        u_o       = 1'b0;
        defined_o = 1'b1;
        unique case (scale_e'(mode))
            SC_NONE: begin e_o = e_m[0]; u_o = u_m[0]; end
            SC_DOWN: begin e_o = e_m[1]; u_o = u_m[1]; end
            SC_UP:   begin e_o = e_m[2]; u_o = u_m[2]; end
            SC_RSV:  defined_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_cc_ovf.sv
// Overflow with optional saturation-limit widening
module acc_cc_ovf #(
    parameter int ACC_W    = 56,
    parameter int EXT_W    = 8,
    parameter int NARROW_W = 32
) (
    input  logic [ACC_W-1:0] res,
    input  logic             add_ovf,
    input  logic             sat_en,
    input  logic             arith16_en,
    output logic             v_o
);
    localparam int LO_WIDE   = ACC_W - EXT_W - 1;
    localparam int LO_NARROW = NARROW_W - 1;

    logic fits_wide;
    logic fits_narrow;

    always_comb begin
        fits_wide   = 1'b1;
        fits_narrow = 1'b1;
        for (int i = 0; i < ACC_W; i++) begin
            if (i >= LO_WIDE && res[i] != res[ACC_W-1]) fits_wide = 1'b0;
            if (i >= LO_NARROW && res[i] != res[ACC_W-1]) fits_narrow = 1'b0;
        end
        v_o = add_ovf | (sat_en & ~(arith16_en ? fits_narrow : fits_wide));
    end

endmodule

// File: rtl/acc_ccgen.sv
module acc_ccgen #(
    parameter int ACC_W    = 56,
    parameter int EXT_W    = 8,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] alu_res,
    input  logic             add_carry,
    input  logic             add_ovf,
    input  logic [1:0]       scale_mode,
    input  logic             sat_en,
    input  logic             arith16_en,
    input  logic             upd,
    input  logic             wr_en,
    input  logic [5:0]       wr_data,
    output logic [5:0]       cc
);
    import acc_cc_pkg::*;

    flags_t flags_q;
    flags_t flags_d;
    logic   e_w;
    logic   u_w;
    logic   win_ok;
    logic   v_w;

    acc_cc_window #(.ACC_W(ACC_W), .EXT_W(EXT_W)) win_i (
        .res       (alu_res),
        .mode      (scale_mode),
        .e_o       (e_w),
        .u_o       (u_w),
        .defined_o (win_ok)
    );

    acc_cc_ovf #(.ACC_W(ACC_W), .EXT_W(EXT_W), .NARROW_W(NARROW_W)) ovf_i (
        .res        (alu_res),
        .add_ovf    (add_ovf),
        .sat_en     (sat_en),
        .arith16_en (arith16_en),
        .v_o        (v_w)
    );

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d = flags_t'(wr_data);
        end else if (upd) begin
            flags_d.c = add_carry;
            flags_d.v = v_w;
            flags_d.z = (alu_res == '0);
            flags_d.n = alu_res[ACC_W-1];
            if (win_ok) begin
                flags_d.u = u_w;
                flags_d.e = e_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAGS_RST;
        else        flags_q <= flags_d;
    end

    assign cc = flags_q;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd) |=> $stable(cc));

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cc == $past(wr_data)));

    // R5
    neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en) |=> (cc[3] == $past(alu_res[ACC_W-1])));

    // R6
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en) |=> (cc[0] == $past(add_carry)));

    // R7
    ovf_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && !sat_en) |=> (cc[1] == $past(add_ovf)));

    // R8
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && add_ovf) |=> cc[1]);

    // R9
    rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && scale_mode == 2'b11) |=> (cc[5:4] == $past(cc[5:4])));

endmodule

// File: tb/acc_ccgen_tb_top.sv
`timescale 1ns/1ps
module acc_ccgen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [55:0] alu_res = '0;
    logic        add_carry = 1'b0;
    logic        add_ovf = 1'b0;
    logic [1:0]  scale_mode = 2'b00;
    logic        sat_en = 1'b0;
    logic        arith16_en = 1'b0;
    logic        upd = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_data = '0;
    logic [5:0]  cc;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [5:0] model = 6'b100000;

    always #10 clk = ~clk;

    acc_ccgen dut_i (
        .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .add_carry(add_carry),
        .add_ovf(add_ovf), .scale_mode(scale_mode), .sat_en(sat_en),
        .arith16_en(arith16_en), .upd(upd), .wr_en(wr_en), .wr_data(wr_data),
        .cc(cc)
    );

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (res=%h mode=%b sat=%b m16=%b)",
                     tag, got, exp, alu_res, scale_mode, sat_en, arith16_en);
        end
    endtask

    function automatic bit fits(input logic [55:0] r, input int nb);
        longint s;
        longint lim;
        s = longint'($signed(r));
        lim = 64'sd1 <<< (nb - 1);
        return (s >= -lim) && (s <= lim - 1);
    endfunction

    function automatic logic [5:0] predict(input logic [5:0] prev, input logic [55:0] r,
                                           input logic c, input logic o, input logic [1:0] m,
                                           input logic s, input logic m16);
        logic [5:0] f;
        int k;
        f = prev;
        f[0] = c;
        f[1] = o | (s & !fits(r, m16 ? 32 : 48));
        f[2] = (r == 56'd0);
        f[3] = longint'($signed(r)) < 0;
        if (m != 2'b11) begin
            k = (m == 2'b00) ? 47 : (m == 2'b01) ? 48 : 46;
            f[5] = !fits(r, k + 1);
            f[4] = (r[k] == r[k-1]);
        end
        return f;
    endfunction

    // drive one update, check result one cycle later
    task automatic apply(input logic [55:0] r, input logic c, input logic o,
                         input logic [1:0] m, input logic s, input logic m16);
        logic [5:0] e;
        alu_res = r; add_carry = c; add_ovf = o; scale_mode = m;
        sat_en = s; arith16_en = m16; upd = 1'b1; wr_en = 1'b0;
        e = predict(model, r, c, o, m, s, m16);
        @(negedge clk);
        model = e;
        chk("R3 E", {5'b0, cc[5]}, {5'b0, e[5]});
        chk("R4 U", {5'b0, cc[4]}, {5'b0, e[4]});
        chk("R5 N/Z", {4'b0, cc[3:2]}, {4'b0, e[3:2]});
        chk("R6 C", {5'b0, cc[0]}, {5'b0, e[0]});
        if (s) chk("R8 V", {5'b0, cc[1]}, {5'b0, e[1]});
        else   chk("R7 V", {5'b0, cc[1]}, {5'b0, e[1]});
        if (m == 2'b11) chk("R9 reserved", cc, e);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        chk("R2 reset", cc, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after reset", cc, 6'b100000);

        // R1: fixed layout on known results (mode none)
        apply(56'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R1 zero layout", cc, 6'b010100);
        apply('1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R1 ones layout", cc, 6'b011001);

        // sweep boundaries for all modes
        idx = 0;
        for (int m = 0; m < 4; m++) begin
            for (int sm = 0; sm < 4; sm++) begin
                for (int j = 0; j < 56; j++) begin
                    longint p;
                    p = 64'sd1 <<< j;
                    for (int v = 0; v < 4; v++) begin
                        longint val;
                        val = (v == 0) ? p : (v == 1) ? p - 1 : (v == 2) ? -p : -p - 1;
                        apply(val[55:0], idx[0], idx[1], m[1:0], sm[0], sm[1]);
                        idx++;
                    end
                end
            end
            // reserved mode right after another mode
            apply(56'h00_8000_0000_0000, 1'b0, 1'b0, m[1:0], 1'b0, 1'b0);
            apply(56'h00_0000_0000_0001, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0);
        end

        // R10: no strobe holds
        upd = 1'b0; wr_en = 1'b0;
        alu_res = 56'h80_0000_0000_0000; add_carry = ~model[0]; add_ovf = 1'b1;
        scale_mode = 2'b00;
        @(negedge clk);
        @(negedge clk);
        chk("R10 hold", cc, model);

        // R11: write wins over update
        for (int w = 0; w < 6; w++) begin
            wr_en = 1'b1; upd = 1'b1; wr_data = 6'b1 << w;
            alu_res = '0; add_carry = 1'b1; add_ovf = 1'b1;
            @(negedge clk);
            chk("R11 write priority", cc, 6'b1 << w);
            model = 6'b1 << w;
        end
        wr_en = 1'b0; upd = 1'b0;
        @(negedge clk);
        chk("R11 written value holds", cc, model);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule